// File: doc/BRIEF.md
# Loop Accelerator Memory Engine

This block drives memory traffic for a hardware loop whose body is a single cycle of combinational logic. An initialization routine programs a start address, a stride, an iteration count, an initial accumulator value and a control word. It then sets the start bit and puts the processor to sleep. The engine fetches one operand per iteration into an input-only register. The external loop body combines that register with the in/out register, and the engine latches the body's result back into the in/out register. If write-back is enabled, the engine stores that result to the address it just read.

The engine generates every address itself. After each iteration it steps the address up or down by the stride, modulo the address space, and it counts iterations down to zero. The loop body therefore holds no address arithmetic and no exit test. In single mode, every word needs its own request and grant. In block mode, the engine issues one request that carries a burst length. It then takes a word in every cycle in which the memory marks its read data valid. When the count runs out, the engine returns to idle and raises an interrupt to wake the processor. The interrupt stays high until software clears it.

Top module: `loop_dma_engine`

## Requirements
- R1: After reset, `busy`, `irq` and `mem_req` are all low.
- R2: In single mode each iteration issues a read of the current address. It captures the returned word into `in_reg_q` on the cycle `mem_rvalid` is high. On the following cycle it loads `io_reg_q` with `body_res`. `in_reg_q` changes only on a cycle where `mem_rvalid` was high.
- R3: `cfg_wdata` bit 1 of the control write (`cfg_sel`=3) selects the direction: 0 steps the address up by the stride after each iteration, 1 steps it down. Addresses wrap modulo 2^AW.
- R4: Control bit 3 enables write-back. It applies in single mode only. Each iteration then writes the new `io_reg_q` value to the address it read, with `mem_len`=1. When the bit is clear, or in block mode, no write is issued.
- R5: A request (`mem_req`) is held with a stable address and direction until `mem_gnt` is high. It is raised only while `busy`. In single mode every read request carries `mem_len`=1.
- R6: Control bit 2 selects block mode. It issues one read request whose `mem_len` equals the iteration count. It then consumes one word on each cycle with `mem_rvalid` high, moving `mem_addr` by the stride after each word. Each word is applied to the loop body one cycle after capture.
- R7: After the programmed number of iterations, `busy` falls and `irq` rises on the same edge. A count of zero raises `irq` on the edge after the start without any memory request.
- R8: `irq` stays high until a write to `cfg_sel`=4. Writes to other selects leave it set.
- R9: A control write with the start bit (bit 0) while `busy` is ignored. Changes to the base, stride, count or init registers during a run do not affect that run.
- R10: At start, `io_reg_q` is loaded from the init register (`cfg_sel`=5). Base is `cfg_sel`=0, stride 1, count 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 base, 1 stride, 2 count, 3 control, 4 interrupt clear, 5 init |
| cfg_wdata | input | DW | Configuration write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address, or the address of the next burst word |
| mem_len | output | CW | Words requested (1 in single mode) |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| in_reg_q | output | DW | Input operand register for the loop body |
| io_reg_q | output | DW | In/out register for the loop body |
| body_res | input | DW | Combinational result of the loop body |
| busy | output | 1 | Loop in progress |
| irq | output | 1 | Completion interrupt |

## Verification
Suppose the address register steps the wrong way or misses a wrap. The very next read then fetches the wrong word, and the bench sees it in the logged read addresses within one iteration. Suppose the iteration counter or the state sequence slips. The number of read requests, write requests or burst beats then differs from the count, and the final in/out value is off by one or more terms. Both show up when `irq` rises. Suppose instead the end of the loop is missed. Then `irq` never rises, and the wait for completion times out.

// File: rtl/loop_dma_engine.sv
module loop_dma_engine #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] mem_len,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] in_reg_q,
  output logic [DW-1:0] io_reg_q,
  input  logic [DW-1:0] body_res,
  output logic          busy,
  output logic          irq
);
  localparam logic [2:0] SEL_BASE = 3'd0, SEL_STRIDE = 3'd1, SEL_COUNT = 3'd2,
                         SEL_CTRL = 3'd3, SEL_CLR = 3'd4, SEL_INIT = 3'd5;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_RWAIT, S_EXEC, S_WRITE, S_NEXT, S_BURST, S_DRAIN
  } state_t;

  state_t        st;
  logic [AW-1:0] base_r, stride_r, addr_q, step_q;
  logic [CW-1:0] count_r, cnt_q;
  logic [DW-1:0] init_r;
  logic          dir_q, blk_q, wb_q, pend_q;

  wire           go      = cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[0] && st == S_IDLE;
  wire [AW-1:0]  addr_nx = dir_q ? addr_q - step_q : addr_q + step_q;
  wire           last    = cnt_q == ONE;

  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_READ || st == S_WRITE;
  assign mem_we    = st == S_WRITE;
  assign mem_addr  = addr_q;
  assign mem_wdata = io_reg_q;
  assign mem_len   = (st == S_READ && blk_q) ? cnt_q : ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_r   <= '0;
      stride_r <= '0;
      count_r  <= '0;
      init_r   <= '0;
      addr_q   <= '0;
      step_q   <= '0;
      cnt_q    <= '0;
      dir_q    <= 1'b0;
      blk_q    <= 1'b0;
      wb_q     <= 1'b0;
      pend_q   <= 1'b0;
      in_reg_q <= '0;
      io_reg_q <= '0;
      irq      <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_BASE:   base_r   <= cfg_wdata[AW-1:0];
          SEL_STRIDE: stride_r <= cfg_wdata[AW-1:0];
          SEL_COUNT:  count_r  <= cfg_wdata[CW-1:0];
          SEL_INIT:   init_r   <= cfg_wdata;
          SEL_CLR:    irq      <= 1'b0;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (go) begin
          dir_q    <= cfg_wdata[1];
          blk_q    <= cfg_wdata[2];
          wb_q     <= cfg_wdata[3];
          addr_q   <= base_r;
          step_q   <= stride_r;
          cnt_q    <= count_r;
          io_reg_q <= init_r;
          pend_q   <= 1'b0;
          if (count_r == '0) irq <= 1'b1;
          else               st  <= S_READ;
        end
        S_READ:  if (mem_gnt) st <= blk_q ? S_BURST : S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          in_reg_q <= mem_rdata;
          st       <= S_EXEC;
        end
        S_EXEC: begin
          io_reg_q <= body_res;
          st       <= wb_q ? S_WRITE : S_NEXT;
        end
        S_WRITE: if (mem_gnt) st <= S_NEXT;
        S_NEXT: begin
          addr_q <= addr_nx;
          cnt_q  <= cnt_q - ONE;
          if (last) begin
            st  <= S_IDLE;
            irq <= 1'b1;
          end else st <= S_READ;
        end
        S_BURST: begin
          pend_q <= mem_rvalid;
          if (pend_q) io_reg_q <= body_res;
          if (mem_rvalid) begin
            in_reg_q <= mem_rdata;
            addr_q   <= addr_nx;
            cnt_q    <= cnt_q - ONE;
            if (last) st <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          io_reg_q <= body_res;
          irq      <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loop_dma_engine_chk.sv
module loop_dma_engine_chk #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] mem_len,
  input logic          mem_gnt,
  input logic          mem_rvalid,
  input logic [DW-1:0] in_reg_q,
  input logic          busy,
  input logic          irq
);
  assert_req_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_write_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_len == CW'(1));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(cfg_we && cfg_sel == 3'd4) |=> irq);

  assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_in_on_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> $stable(in_reg_q));
endmodule

bind loop_dma_engine loop_dma_engine_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
  .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .in_reg_q(in_reg_q),
  .busy(busy), .irq(irq)
);

// File: tb/loop_dma_engine_tb.sv
module loop_dma_engine_tb;
  localparam int DW = 16, AW = 12, CW = 8;
  localparam int MSZ = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] stride;
    logic [CW-1:0] count;
    logic          dir;
    logic          blk;
    logic          wb;
    logic [DW-1:0] init;
    logic [DW-1:0] k;
    logic [3:0]    lat;
    logic          gap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{12'd10,   12'd1, 8'd5, 1'b0, 1'b0, 1'b0, 16'd0, 16'h0000, 4'd0, 1'b0},
    '{12'd100,  12'd4, 8'd6, 1'b1, 1'b0, 1'b1, 16'd3, 16'h00F0, 4'd2, 1'b0},
    '{12'd2,    12'd3, 8'd4, 1'b1, 1'b0, 1'b1, 16'd1, 16'h0005, 4'd1, 1'b0},
    '{12'd40,   12'd2, 8'd8, 1'b0, 1'b1, 1'b0, 16'd7, 16'h0000, 4'd1, 1'b0},
    '{12'd4090, 12'd5, 8'd7, 1'b0, 1'b1, 1'b1, 16'd0, 16'h0003, 4'd3, 1'b1},
    '{12'd200,  12'd0, 8'd3, 1'b0, 1'b0, 1'b1, 16'd9, 16'h0001, 4'd0, 1'b0},
    '{12'd7,    12'd1, 8'd1, 1'b0, 1'b1, 1'b0, 16'd2, 16'h0000, 4'd0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_len;
  logic [DW-1:0] mem_wdata;
  logic          mem_gnt = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] in_reg_q, io_reg_q, body_res;
  logic          busy, irq;

  logic [DW-1:0] k_q = '0;
  logic [3:0]    gnt_lat = '0;
  logic          gap_en = 1'b0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign body_res = (io_reg_q + in_reg_q) ^ k_q;

  loop_dma_engine #(.DW(DW), .AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .in_reg_q(in_reg_q), .io_reg_q(io_reg_q), .body_res(body_res), .busy(busy), .irq(irq)
  );

  logic [DW-1:0] mem_arr [MSZ];
  logic [DW-1:0] exp_mem [MSZ];
  logic [AW-1:0] log_addr [256];
  int            n_log = 0;
  int            rd_cnt = 0;
  int            wr_cnt = 0;
  logic [CW-1:0] last_len = '0;
  int            wait_cnt = 0;
  int            beats = 0;
  logic          stall_t = 1'b0;
  logic          lat_we = 1'b0;
  logic [AW-1:0] lat_addr = '0;
  logic [DW-1:0] lat_wdata = '0;
  logic [CW-1:0] lat_len = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MSZ; i++) mem_arr[i] = DW'(i * 37 + 11);
      mem_gnt = 1'b0;
      mem_rvalid = 1'b0;
      beats = 0;
      wait_cnt = 0;
    end else begin
      mem_rvalid = 1'b0;
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        if (lat_we) begin
          mem_arr[lat_addr] = lat_wdata;
          wr_cnt++;
        end else begin
          rd_cnt++;
          last_len = lat_len;
          beats = int'(lat_len);
        end
      end else if (mem_req) begin
        if (wait_cnt >= int'(gnt_lat)) begin
          mem_gnt = 1'b1;
          lat_we = mem_we;
          lat_addr = mem_addr;
          lat_wdata = mem_wdata;
          lat_len = mem_len;
          wait_cnt = 0;
        end else wait_cnt++;
      end else wait_cnt = 0;
      if (beats > 0) begin
        stall_t = ~stall_t;
        if (!(gap_en && stall_t)) begin
          mem_rvalid = 1'b1;
          mem_rdata = mem_arr[mem_addr];
          if (n_log < 256) log_addr[n_log] = mem_addr;
          n_log++;
          beats--;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [DW-1:0] acc;
    logic [AW-1:0] a;
    logic [AW-1:0] ea [256];
    int rd0, wr0, lg0, bad, exp_wr, exp_rd, membad;
    k_q = v.k;
    gnt_lat = v.lat;
    gap_en = v.gap;
    acc = v.init;
    a = v.base;
    for (int i = 0; i < int'(v.count); i++) begin
      ea[i] = a;
      acc = (acc + exp_mem[a]) ^ v.k;
      if (v.wb && !v.blk) exp_mem[a] = acc;
      a = v.dir ? a - v.stride : a + v.stride;
    end
    exp_wr = (v.wb && !v.blk) ? int'(v.count) : 0;
    exp_rd = v.blk ? 1 : int'(v.count);
    rd0 = rd_cnt; wr0 = wr_cnt; lg0 = n_log;
    cfg_write(3'd0, DW'(v.base));
    cfg_write(3'd1, DW'(v.stride));
    cfg_write(3'd2, DW'(v.count));
    cfg_write(3'd5, v.init);
    cfg_write(3'd3, DW'({v.wb, v.blk, v.dir, 1'b1}));
    wait_irq();
    @(negedge clk);
    chk($sformatf("R7 v%0d irq at end", idx), 32'(irq), 32'd1);
    chk($sformatf("R7 v%0d busy at end", idx), 32'(busy), 32'd0);
    chk($sformatf("%s R10 v%0d io result", v.blk ? "R6" : "R2", idx), 32'(io_reg_q), 32'(acc));
    bad = (n_log - lg0 != int'(v.count)) ? 1 : 0;
    for (int i = 0; i < int'(v.count); i++)
      if (log_addr[lg0 + i] !== ea[i]) bad++;
    chk($sformatf("R3 v%0d read address sequence", idx), 32'(bad), 32'd0);
    chk($sformatf("R4 v%0d write count", idx), 32'(wr_cnt - wr0), 32'(exp_wr));
    membad = 0;
    for (int i = 0; i < MSZ; i++) if (mem_arr[i] !== exp_mem[i]) membad++;
    chk($sformatf("R4 v%0d memory image", idx), 32'(membad), 32'd0);
    chk($sformatf("%s v%0d read requests", v.blk ? "R6" : "R5", idx), 32'(rd_cnt - rd0), 32'(exp_rd));
    chk($sformatf("%s v%0d last read length", v.blk ? "R6" : "R5", idx), 32'(last_len),
        v.blk ? 32'(v.count) : 32'd1);
    cfg_write(3'd4, '0);
    chk($sformatf("R8 v%0d irq cleared", idx), 32'(irq), 32'd0);
  endtask

  task automatic run_all();
    int rd0;
    logic [DW-1:0] s;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

    rd0 = rd_cnt;
    cfg_write(3'd2, '0);
    cfg_write(3'd3, DW'(1));
    chk("R7 zero count irq", 32'(irq), 32'd1);
    chk("R7 zero count idle", 32'(busy), 32'd0);
    chk("R7 zero count no request", 32'(rd_cnt - rd0), 32'd0);
    cfg_write(3'd0, DW'(5));
    chk("R8 irq kept by other write", 32'(irq), 32'd1);
    cfg_write(3'd4, '0);
    chk("R8 irq cleared", 32'(irq), 32'd0);

    k_q = '0; gnt_lat = 4'd6; gap_en = 1'b0;
    s = '0;
    for (int i = 0; i < 4; i++) s = s + exp_mem[300 + i];
    rd0 = rd_cnt;
    cfg_write(3'd0, DW'(300));
    cfg_write(3'd1, DW'(1));
    cfg_write(3'd2, DW'(4));
    cfg_write(3'd5, '0);
    cfg_write(3'd3, DW'(1));
    repeat (3) @(negedge clk);
    cfg_write(3'd2, DW'(9));
    cfg_write(3'd3, DW'(5));
    wait_irq();
    @(negedge clk);
    chk("R9 restart ignored result", 32'(io_reg_q), 32'(s));
    chk("R9 restart ignored requests", 32'(rd_cnt - rd0), 32'd4);
    chk("R9 restart ignored length", 32'(last_len), 32'd1);
    cfg_write(3'd4, '0);
  endtask

  initial begin
    logic wd;
    wd = 1'b0;
    for (int i = 0; i < MSZ; i++) exp_mem[i] = DW'(i * 37 + 11);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule